// File: doc/BRIEF.md
# Dual-Event Performance Counter Unit

This block is a processor performance-monitoring unit with two 32-bit event counters. Software programs a control word that selects one of sixteen event lines for each counter. The same word chooses which privilege states are allowed to count and holds a global run bit. On every clock edge where counting is allowed and the chosen event line is high, a counter advances by one.

Both counters share one 64-bit count register, so one write reloads both. Software arms a sampling period by preloading a counter with 0x80000000 minus the period. When either counter's most significant bit becomes set while the run bit is on, a level interrupt is raised. It stays raised until software rewrites the count register with values that have that bit clear. Sample collection, reload policy and interrupt routing are left to software.

Top module: `dual_evt_pmu`

## Requirements
- R1: A synchronous active-high reset clears the control word, both counters and the interrupt output.
- R2: A counter counts only when the qualifying bit for the current state is set. Control bit 0 qualifies exception level, and exception level overrides the privilege code. Otherwise bit 1 qualifies kernel (priv_mode 0), bit 2 qualifies supervisor (priv_mode 1) and bit 3 qualifies user (priv_mode 2).
- R3: Control bit 4 is the global run bit. While it is clear, neither counter changes except by a count-register write, and the interrupt output is low.
- R4: Counter 0 follows the event line numbered by control bits 8:5, and counter 1 follows the event line numbered by control bits 12:9. Each adds exactly one per qualifying edge.
- R5: The count register (reg_sel = 1) holds counter 0 in bits 31:0 and counter 1 in bits 63:32. One write loads both counters.
- R6: The interrupt output equals the run bit ANDed with the OR of bit 31 of both counters. A count write with bit 31 clear in both halves drops it.
- R7: A count-register write on the same edge as an increment takes precedence, and the written value is loaded unchanged.
- R8: A counter keeps counting past bit 31 and wraps from 0xFFFFFFFF to 0. It does not saturate.
- R9: The control register (reg_sel = 0) stores write-data bits 12:0, ignores higher bits and reads back zero-extended. reg_rdata shows the selected register as it stood before the edge that samples reg_rsel.
- R10: A priv_mode value of 3 outside exception level never allows counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 control, 1 count |
| reg_wdata | input | 64 | Write data |
| reg_rsel | input | 1 | Read source: 0 control, 1 count |
| reg_rdata | output | 64 | Registered read data |
| evt_in | input | 16 | Event lines, one per event number |
| exc_lvl | input | 1 | Processor is at exception level |
| priv_mode | input | 2 | Privilege code: 0 kernel, 1 supervisor, 2 user, 3 none |
| irq | output | 1 | Level overflow interrupt |

## Verification
A bad gating decision in the qualification logic shows up one edge later as a count that moved when it should have held, or held when it should have moved. It is visible on the next read of the count register, and through irq once a preloaded counter crosses bit 31. A wrong selector offset makes a counter follow the wrong event line, so the two halves of the count register drift apart from each other within a few cycles of random events. A wrong precedence between a write and an increment leaves the readback one above the value just written. An interrupt fed from stale state lags the counter crossing by one cycle, which a cycle-by-cycle comparison of irq catches at once.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int MODE_EXC      = 0;
  localparam int MODE_KERN     = 1;
  localparam int MODE_SUP      = 2;
  localparam int MODE_USR      = 3;
  localparam int RUN_BIT       = 4;
  localparam int SEL_BASE      = 5;

  typedef enum logic [1:0] {
    PRIV_KERNEL = 2'd0,
    PRIV_SUPER  = 2'd1,
    PRIV_USER   = 2'd2,
    PRIV_NONE   = 2'd3
  } priv_e;

  localparam logic SEL_CTRL  = 1'b0;
  localparam logic SEL_COUNT = 1'b1;
endpackage

// File: rtl/pmu_ctrl_reg.sv
module pmu_ctrl_reg
  import pmu_pkg::*;
#(
  parameter int NUM_EVT = 16,
  parameter int NUM_CNT = 2,
  localparam int SEL_W  = $clog2(NUM_EVT),
  localparam int CTRL_W = SEL_BASE + NUM_CNT * SEL_W
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_ctrl,
  input  logic [CTRL_W-1:0]               wr_bits,
  input  logic                            exc_lvl,
  input  logic [1:0]                      priv,
  output logic [CTRL_W-1:0]               ctrl_q,
  output logic                            run_en,
  output logic                            mode_ok,
  output logic [NUM_CNT-1:0][SEL_W-1:0]   sel
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= wr_bits;
    end
  end

  assign run_en = ctrl_q[RUN_BIT];

  // exception level overrides the privilege code
  always_comb begin
    if (exc_lvl) begin
      mode_ok = ctrl_q[MODE_EXC];
    end else begin
      case (priv_e'(priv))
        PRIV_KERNEL: mode_ok = ctrl_q[MODE_KERN];
        PRIV_SUPER:  mode_ok = ctrl_q[MODE_SUP];
        PRIV_USER:   mode_ok = ctrl_q[MODE_USR];
        default:     mode_ok = 1'b0;
      endcase
    end
  end

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_sel
    assign sel[k] = ctrl_q[SEL_BASE + k*SEL_W +: SEL_W];
  end

endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 16,
  localparam int SEL_W  = $clog2(NUM_EVT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [CNT_W-1:0]   load_val,
  input  logic               allow,
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_EVT-1:0] evt_in,
  output logic [CNT_W-1:0]   cnt_q,
  output logic               ovf_next
);

  logic             hit;
  logic [CNT_W-1:0] cnt_next;

  assign hit = allow & evt_in[sel];

  // a load overrides a same-edge increment; the adder wraps freely
  always_comb begin
    if (load) begin
      cnt_next = load_val;
    end else if (hit) begin
      cnt_next = cnt_q + CNT_W'(1);
    end else begin
      cnt_next = cnt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_next;
    end
  end

  assign ovf_next = cnt_next[CNT_W-1];

endmodule

// File: rtl/dual_evt_pmu.sv
module dual_evt_pmu
  import pmu_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 16,
  localparam int NUM_CNT = 2,
  localparam int SEL_W   = $clog2(NUM_EVT),
  localparam int CTRL_W  = SEL_BASE + NUM_CNT * SEL_W,
  localparam int DATA_W  = NUM_CNT * CNT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_sel,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic               reg_rsel,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               exc_lvl,
  input  logic [1:0]         priv_mode,
  output logic               irq
);

  logic                          wr_ctrl;
  logic                          wr_count;
  logic [CTRL_W-1:0]             ctrl_q;
  logic                          run_en;
  logic                          mode_ok;
  logic                          allow;
  logic                          run_next;
  logic [NUM_CNT-1:0][SEL_W-1:0] sel;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val;
  logic [NUM_CNT-1:0]            ovf_next;

  assign wr_ctrl  = reg_wr & (reg_sel == SEL_CTRL);
  assign wr_count = reg_wr & (reg_sel == SEL_COUNT);

  pmu_ctrl_reg #(
    .NUM_EVT (NUM_EVT),
    .NUM_CNT (NUM_CNT)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_ctrl (wr_ctrl),
    .wr_bits (reg_wdata[CTRL_W-1:0]),
    .exc_lvl (exc_lvl),
    .priv    (priv_mode),
    .ctrl_q  (ctrl_q),
    .run_en  (run_en),
    .mode_ok (mode_ok),
    .sel     (sel)
  );

  assign allow = run_en & mode_ok;

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    pmu_counter #(
      .CNT_W   (CNT_W),
      .NUM_EVT (NUM_EVT)
    ) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .load     (wr_count),
      .load_val (reg_wdata[k*CNT_W +: CNT_W]),
      .allow    (allow),
      .sel      (sel[k]),
      .evt_in   (evt_in),
      .cnt_q    (cnt_val[k]),
      .ovf_next (ovf_next[k])
    );
  end

  // interrupt register is fed from next state so it lines up with the counters
  assign run_next = wr_ctrl ? reg_wdata[RUN_BIT] : run_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else begin
      irq <= run_next & (|ovf_next);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rsel == SEL_COUNT) begin
      reg_rdata <= cnt_val;
    end else begin
      reg_rdata <= DATA_W'(ctrl_q);
    end
  end

endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
  parameter int CNT_W  = 32,
  parameter int CTRL_W = 13
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  reg_wr,
  input logic                  reg_sel,
  input logic [2*CNT_W-1:0]    reg_wdata,
  input logic                  exc_lvl,
  input logic [1:0]            priv_mode,
  input logic                  irq,
  input logic [CTRL_W-1:0]     ctrl_q,
  input logic [1:0][CNT_W-1:0] cnt_val
);

  logic cnt_wr;
  assign cnt_wr = reg_wr & reg_sel;

  p_irq_level_r6: assert property (@(posedge clk) disable iff (rst)
    irq == (ctrl_q[4] && (cnt_val[0][CNT_W-1] || cnt_val[1][CNT_W-1])));

  p_write_wins_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (cnt_val == $past(reg_wdata)));

  p_step_one_r4: assert property (@(posedge clk) disable iff (rst)
    !cnt_wr |=> ((cnt_val[0] == $past(cnt_val[0])) || (cnt_val[0] == $past(cnt_val[0]) + CNT_W'(1)))
             && ((cnt_val[1] == $past(cnt_val[1])) || (cnt_val[1] == $past(cnt_val[1]) + CNT_W'(1))));

  p_run_off_r3: assert property (@(posedge clk) disable iff (rst)
    (!cnt_wr && !ctrl_q[4]) |=> $stable(cnt_val));

  p_exc_gate_r2: assert property (@(posedge clk) disable iff (rst)
    (!cnt_wr && exc_lvl && !ctrl_q[0]) |=> $stable(cnt_val));

  p_no_priv_r10: assert property (@(posedge clk) disable iff (rst)
    (!cnt_wr && !exc_lvl && priv_mode == 2'd3) |=> $stable(cnt_val));

  p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (!cnt_wr && cnt_val[0] == '1) |=> (cnt_val[0] == '0 || cnt_val[0] == '1));

endmodule

bind dual_evt_pmu pmu_checker #(
  .CNT_W  (CNT_W),
  .CTRL_W (CTRL_W)
) u_pmu_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .exc_lvl   (exc_lvl),
  .priv_mode (priv_mode),
  .irq       (irq),
  .ctrl_q    (ctrl_q),
  .cnt_val   (cnt_val)
);

// File: tb/dual_evt_pmu_bench.sv
`timescale 1ns/1ps
module dual_evt_pmu_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [63:0] reg_wdata = '0;
  logic        reg_rsel = 1'b0;
  logic [63:0] reg_rdata;
  logic [15:0] evt_in = '0;
  logic        exc_lvl = 1'b0;
  logic [1:0]  priv_mode = 2'd0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [12:0] m_ctrl;
  logic [31:0] m_c0, m_c1;
  logic [63:0] rd_exp;
  logic        irq_exp;

  always #2.5 clk = ~clk;

  dual_evt_pmu u_dual_evt_pmu (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rsel(reg_rsel), .reg_rdata(reg_rdata),
    .evt_in(evt_in), .exc_lvl(exc_lvl), .priv_mode(priv_mode), .irq(irq)
  );

  function automatic logic mode_ok_m(logic [12:0] c, logic e, logic [1:0] p);
    if (e) return c[0];
    case (p)
      2'd0: return c[1];
      2'd1: return c[2];
      2'd2: return c[3];
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // drive at negedge, model the edge, compare at the next negedge
  task automatic step(string req);
    logic allow;
    @(posedge clk);
    #1;
    rd_exp = reg_rsel ? {m_c1, m_c0} : {51'b0, m_ctrl};
    allow = m_ctrl[4] && mode_ok_m(m_ctrl, exc_lvl, priv_mode);
    if (reg_wr && reg_sel) begin
      m_c0 = reg_wdata[31:0];
      m_c1 = reg_wdata[63:32];
    end else begin
      if (allow && evt_in[m_ctrl[8:5]])  m_c0 = m_c0 + 32'd1;
      if (allow && evt_in[m_ctrl[12:9]]) m_c1 = m_c1 + 32'd1;
    end
    if (reg_wr && !reg_sel) m_ctrl = reg_wdata[12:0];
    irq_exp = m_ctrl[4] && (m_c0[31] || m_c1[31]);
    @(negedge clk);
    check({req, " rdata"}, reg_rdata, rd_exp);
    check({req, " irq"}, {63'b0, irq}, {63'b0, irq_exp});
  endtask

  task automatic idle();
    reg_wr = 1'b0;
  endtask

  task automatic wr(logic sel, logic [63:0] d, string req);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    step(req);
    reg_wr = 1'b0;
  endtask

  task automatic rd_now(logic sel, string req);
    reg_rsel = sel;
    step(req);
    step(req);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    m_ctrl = '0; m_c0 = '0; m_c1 = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    rd_now(1'b0, "R1 ctrl after reset");
    rd_now(1'b1, "R1 count after reset");

    // R9: upper write bits ignored
    wr(1'b0, 64'hFFFF_FFFF_FFFF_E0F0, "R9 ctrl write");
    rd_now(1'b0, "R9 ctrl readback");

    // R4: counter 0 on event 3, counter 1 on event 9, kernel only
    wr(1'b0, {51'b0, 4'd9, 4'd3, 1'b1, 4'b0010}, "R4 select");
    reg_rsel = 1'b1; exc_lvl = 1'b0; priv_mode = 2'd0;
    evt_in = 16'h0008; repeat (3) step("R4 event3");
    evt_in = 16'h0200; repeat (2) step("R4 event9");
    evt_in = 16'hFDF7; repeat (2) step("R4 other events");

    // R2: supervisor and user not qualified, exception not qualified
    evt_in = 16'hFFFF;
    priv_mode = 2'd1; repeat (2) step("R2 super blocked");
    priv_mode = 2'd2; repeat (2) step("R2 user blocked");
    priv_mode = 2'd0; exc_lvl = 1'b1; repeat (2) step("R2 exc overrides kernel");
    exc_lvl = 1'b0;
    // R10: priv code 3 with every mode bit set
    wr(1'b0, {51'b0, 4'd9, 4'd3, 1'b1, 4'b1111}, "R10 all modes");
    priv_mode = 2'd3; repeat (2) step("R10 no privilege");
    priv_mode = 2'd2; repeat (2) step("R2 user allowed");

    // R6/R8: preload near overflow and top
    wr(1'b1, {32'hFFFF_FFFE, 32'h7FFF_FFFE}, "R5 dual load");
    repeat (4) step("R6 R8 crossing");
    wr(1'b1, {32'h0000_0010, 32'h0000_0020}, "R6 clear by write");
    // R7: write with event high
    wr(1'b1, {32'h1234_5678, 32'h7FFF_FFFF}, "R7 write wins");
    step("R6 overflow next");
    // R3: run bit off
    wr(1'b0, {51'b0, 4'd9, 4'd3, 1'b0, 4'b1111}, "R3 run off");
    repeat (3) step("R3 frozen and irq low");
    wr(1'b0, 64'd0, "R3 stop all");
    step("R3 stopped");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 15);
      evt_in = 16'($urandom);
      exc_lvl = ($urandom_range(0, 7) == 0);
      priv_mode = 2'($urandom);
      reg_rsel = 1'($urandom);
      if (r == 0) begin
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = {32'($urandom), 32'($urandom)} | 64'h10;
      end else if (r == 1) begin
        reg_wr = 1'b1; reg_sel = 1'b1;
        case ($urandom_range(0, 2))
          0: reg_wdata = {32'hFFFF_FFF0 | 32'($urandom_range(0, 15)), 32'h7FFF_FFF0 | 32'($urandom_range(0, 15))};
          1: reg_wdata = {32'h7FFF_FFF8, 32'hFFFF_FFFA};
          default: reg_wdata = {32'($urandom), 32'($urandom)};
        endcase
      end else begin
        reg_wr = 1'b0;
      end
      step("R2 R4 R6 R7 R8 random");
    end
    idle();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule